// File: doc/BRIEF.md
# Video Memory Command Port Decoder

This block sits behind the control port of a video controller. A host builds one memory access command by writing two 16-bit words to that port. Each word carries a different slice of a 16-bit video memory address and of a 6-bit access code. The first word sets a pending interlock. The second word completes the command and clears the interlock. Reading the control port, or any read or write on the data port, cancels a half-built command.

The completed code is decoded into a memory target and a transfer direction. The targets are word VRAM, colour RAM, scroll RAM and byte-wide VRAM. When the second word sets the top code bit and DMA is enabled, a one-cycle DMA-start pulse is given. Every completed command also pulses a strobe that tells the read-prefetch logic to drop any fetched or half-fetched read data.

All state updates on the rising clock edge on which a strobe is sampled. The address, code and pending outputs show the new values in the following cycle.

Top module: `vcmd_decoder`

## Requirements
- R1: A control write while pending is clear is a first word. It loads cmdAddr[13:0] from wrData[13:0] and cmdCode[1:0] from wrData[15:14]. It keeps cmdAddr[15:14] and cmdCode[5:2], and it sets pending.
- R2: A control write while pending is set is a second word. It loads cmdAddr[15:14] from wrData[1:0] and cmdCode[5:2] from wrData[7:4]. It keeps the other bits and clears pending.
- R3: ctrlRdEn or dataAccEn clears pending and leaves cmdAddr and cmdCode unchanged.
- R4: When a cancel falls in the same cycle as a first word, the first word still loads its fields, but pending stays clear. When a cancel falls in the same cycle as a second word, the command completes normally.
- R5: writeDir equals cmdCode[0], where 1 means a write.
- R6: memTarget is {cmdCode[2], cmdCode[1] | cmdCode[3]}. The encodings are 00 word VRAM, 01 colour RAM, 10 scroll RAM and 11 byte VRAM. So codes 0, 8, 4 and 0xC read VRAM, colour RAM, scroll RAM and byte VRAM, and codes 1, 3 and 5 write VRAM, colour RAM and scroll RAM.
- R7: dmaStart is high for exactly the one cycle after a second word with wrData[7] = 1 and dmaEnable = 1. With dmaEnable = 0, no pulse is given, but cmdCode[5] is still stored.
- R8: prefetchClr is high for exactly the one cycle after each second word, and at no other time.
- R9: After reset, cmdAddr, cmdCode, pending, dmaStart and prefetchClr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control port write strobe |
| ctrlRdEn | input | 1 | Control port read strobe (cancels pending) |
| dataAccEn | input | 1 | Data port read or write strobe (cancels pending) |
| wrData | input | 16 | Control port write value |
| dmaEnable | input | 1 | DMA enable bit from the mode register |
| cmdAddr | output | 16 | Assembled video memory address |
| cmdCode | output | 6 | Assembled access code |
| pending | output | 1 | First word received, second awaited |
| memTarget | output | 2 | Decoded memory target |
| writeDir | output | 1 | 1 = write access, 0 = read access |
| dmaStart | output | 1 | One-cycle DMA request pulse |
| prefetchClr | output | 1 | One-cycle prefetch-state clear pulse |

## Verification
A cancel strobe and a control write can arrive in the same cycle, and the outcome depends on which word the write is. The bench drives a data access or a control read together with a first word, and expects the fields to load while pending stays clear. It then drives a cancel together with a second word, and expects a normal completion with the DMA and prefetch pulses. Each case is judged against a model that the scoreboard advances per cycle from the stated rules.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'b00,
    TGT_CRAM  = 2'b01,
    TGT_VSRAM = 2'b10,
    TGT_VRAM8 = 2'b11
  } target_e;

  typedef struct packed {
    logic ldFirst;
    logic ldSecond;
  } strobe_t;

endpackage

// File: rtl/vcmd_ctrl.sv
module vcmd_ctrl
  import vcmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctrlWrEn,
  input  logic    ctrlRdEn,
  input  logic    dataAccEn,
  input  logic    dmaBitIn,
  input  logic    dmaEnable,
  output strobe_t strb,
  output logic    pending,
  output logic    dmaStart,
  output logic    prefetchClr
);

  logic cancel;
  logic pendNext;

  assign cancel        = ctrlRdEn | dataAccEn;
  assign strb.ldFirst  = ctrlWrEn & ~pending;
  assign strb.ldSecond = ctrlWrEn & pending;

  always_comb begin
    pendNext = pending;
    if (strb.ldSecond)     pendNext = 1'b0;
    else if (cancel)       pendNext = 1'b0;
    else if (strb.ldFirst) pendNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      dmaStart    <= 1'b0;
      prefetchClr <= 1'b0;
    end else begin
      pending     <= pendNext;
      dmaStart    <= strb.ldSecond & dmaBitIn & dmaEnable;
      prefetchClr <= strb.ldSecond;
    end
  end

  // R1: a first word with no cancel leaves pending set
  a_r1_first_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !pending && !cancel) |=> pending);

  // R2: a second word always clears pending
  a_r2_second_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && pending) |=> !pending);

  // R3: a cancel leaves pending clear
  a_r3_cancel_clears: assert property (@(posedge clk) disable iff (!rstN)
    cancel |=> !pending);

  // R8: the prefetch clear follows only a completed command
  a_r8_prefetch_after_second: assert property (@(posedge clk) disable iff (!rstN)
    prefetchClr |-> ($past(pending) && !pending));

  // R7: DMA start never comes without enable
  a_r7_dma_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart |-> ($past(dmaEnable) && prefetchClr));

endmodule

// File: rtl/vcmd_datapath.sv
module vcmd_datapath
  import vcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] wrData,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [CODE_W-1:0] cmdCode,
  output target_e           memTarget,
  output logic              writeDir
);

  localparam int ADDR_LO_W = ADDR_W - 2;
  localparam int CODE_LO_W = 2;
  localparam int CODE_HI_W = CODE_W - CODE_LO_W;
  localparam int HI_CODE_POS = 4;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAddr <= '0;
      cmdCode <= '0;
    end else if (strb.ldFirst) begin
      cmdAddr[ADDR_LO_W-1:0] <= wrData[ADDR_LO_W-1:0];
      cmdCode[CODE_LO_W-1:0] <= wrData[WORD_W-1 -: CODE_LO_W];
    end else if (strb.ldSecond) begin
      cmdAddr[ADDR_W-1:ADDR_LO_W] <= wrData[ADDR_W-ADDR_LO_W-1:0];
      cmdCode[CODE_W-1:CODE_LO_W] <= wrData[HI_CODE_POS +: CODE_HI_W];
    end
  end

  assign writeDir  = cmdCode[0];
  assign memTarget = target_e'({cmdCode[2], cmdCode[1] | cmdCode[3]});

  // R1: the first word keeps the upper address bits and the upper code bits
  a_r1_first_keeps_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldFirst |=> (cmdAddr[ADDR_W-1:ADDR_LO_W] == $past(cmdAddr[ADDR_W-1:ADDR_LO_W])
                      && cmdCode[CODE_W-1:CODE_LO_W] == $past(cmdCode[CODE_W-1:CODE_LO_W])));

  // R2: the second word keeps the lower address bits and the lower code bits
  a_r2_second_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldSecond |=> (cmdAddr[ADDR_LO_W-1:0] == $past(cmdAddr[ADDR_LO_W-1:0])
                       && cmdCode[CODE_LO_W-1:0] == $past(cmdCode[CODE_LO_W-1:0])));

endmodule

// File: rtl/vcmd_decoder.sv
module vcmd_decoder
  import vcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CODE_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              ctrlRdEn,
  input  logic              dataAccEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              dmaEnable,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [CODE_W-1:0] cmdCode,
  output logic              pending,
  output logic [1:0]        memTarget,
  output logic              writeDir,
  output logic              dmaStart,
  output logic              prefetchClr
);

  localparam int DMA_BIT_POS = 4 + CODE_W - 3;

  strobe_t strb;
  target_e tgt;

  vcmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlRdEn   (ctrlRdEn),
    .dataAccEn  (dataAccEn),
    .dmaBitIn   (wrData[DMA_BIT_POS]),
    .dmaEnable  (dmaEnable),
    .strb       (strb),
    .pending    (pending),
    .dmaStart   (dmaStart),
    .prefetchClr(prefetchClr)
  );

  vcmd_datapath #(
    .ADDR_W(ADDR_W),
    .CODE_W(CODE_W),
    .WORD_W(WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .cmdAddr  (cmdAddr),
    .cmdCode  (cmdCode),
    .memTarget(tgt),
    .writeDir (writeDir)
  );

  assign memTarget = tgt;

  // R3: a cancel with no control write changes neither address nor code
  a_r3_cancel_no_change: assert property (@(posedge clk) disable iff (!rstN)
    ((ctrlRdEn || dataAccEn) && !ctrlWrEn) |=> ($stable(cmdAddr) && $stable(cmdCode)));

  // R7: a DMA start pulse carries the stored top code bit
  a_r7_dma_code_bit: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart |-> cmdCode[CODE_W-1]);

endmodule

// File: tb/vcmd_decoder_tb.sv
module vcmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctrlWrEn, ctrlRdEn, dataAccEn, dmaEnable;
  logic [15:0] wrData;
  logic [15:0] cmdAddr;
  logic [5:0]  cmdCode;
  logic        pending, writeDir, dmaStart, prefetchClr;
  logic [1:0]  memTarget;

  always #5 clk = ~clk;

  vcmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlRdEn(ctrlRdEn),
    .dataAccEn(dataAccEn), .wrData(wrData), .dmaEnable(dmaEnable),
    .cmdAddr(cmdAddr), .cmdCode(cmdCode), .pending(pending),
    .memTarget(memTarget), .writeDir(writeDir), .dmaStart(dmaStart),
    .prefetchClr(prefetchClr)
  );

  typedef struct {
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pend;
    logic [1:0]  tgt;
    logic        wdir;
    logic        dma;
    logic        pfc;
    string       req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  logic [15:0] mAddr;
  logic [5:0]  mCode;
  logic        mPend;

  function automatic logic [1:0] expTarget(logic [5:0] c);
    // R6 mapping: 00 VRAM, 01 colour RAM, 10 scroll RAM, 11 byte VRAM
    return {c[2], c[1] | c[3]};
  endfunction

  task automatic stepCycle(input logic wr, input logic rd, input logic acc,
                           input logic [15:0] d, input logic den, input string req);
    exp_t e;
    logic dmaE, pfcE;
    @(negedge clk);
    ctrlWrEn = wr; ctrlRdEn = rd; dataAccEn = acc; wrData = d; dmaEnable = den;
    @(posedge clk);
    #1;
    dmaE = 1'b0; pfcE = 1'b0;
    if (wr && mPend) begin
      mAddr[15:14] = d[1:0];
      mCode[5:2]   = d[7:4];
      mPend        = 1'b0;
      pfcE         = 1'b1;
      dmaE         = d[7] & den;
    end else if (wr) begin
      mAddr[13:0] = d[13:0];
      mCode[1:0]  = d[15:14];
      mPend       = !(rd || acc);
    end else if (rd || acc) begin
      mPend = 1'b0;
    end
    e.addr = mAddr; e.code = mCode; e.pend = mPend;
    e.tgt = expTarget(mCode); e.wdir = mCode[0];
    e.dma = dmaE; e.pfc = pfcE; e.req = req;
    expQ.push_back(e);
    ctrlWrEn = 0; ctrlRdEn = 0; dataAccEn = 0;
  endtask

  task automatic sendCmd(input logic [15:0] a, input logic [5:0] c,
                         input logic den, input string req);
    stepCycle(1, 0, 0, {c[1:0], a[13:0]}, den, req);
    stepCycle(1, 0, 0, {8'h00, c[5:2], 2'b00, a[15:14]}, den, req);
  endtask

  task automatic idle(input string req);
    stepCycle(0, 0, 0, 16'h0000, 1'b0, req);
  endtask

  // monitor: compare each expected item half a cycle after its edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (cmdAddr !== e.addr || cmdCode !== e.code || pending !== e.pend ||
          memTarget !== e.tgt || writeDir !== e.wdir || dmaStart !== e.dma ||
          prefetchClr !== e.pfc) begin
        errors++;
        $display("FAIL %s: got addr=%h code=%h pend=%b tgt=%b wdir=%b dma=%b pfc=%b exp addr=%h code=%h pend=%b tgt=%b wdir=%b dma=%b pfc=%b",
                 e.req, cmdAddr, cmdCode, pending, memTarget, writeDir, dmaStart, prefetchClr,
                 e.addr, e.code, e.pend, e.tgt, e.wdir, e.dma, e.pfc);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; ctrlWrEn = 0; ctrlRdEn = 0; dataAccEn = 0; wrData = 16'h0; dmaEnable = 0;
    mAddr = '0; mCode = '0; mPend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R9: reset state
    idle("R9");

    // R1 and R2: field assembly, VRAM read
    stepCycle(1, 0, 0, 16'h3ABC, 0, "R1");
    stepCycle(1, 0, 0, 16'h0002, 0, "R2");
    // R6 and R5: each read and write code
    sendCmd(16'h1234, 6'h00, 0, "R6");
    sendCmd(16'h4002, 6'h08, 0, "R6");
    sendCmd(16'h8010, 6'h04, 0, "R6");
    sendCmd(16'hC0FE, 6'h0C, 0, "R6");
    sendCmd(16'h0100, 6'h01, 0, "R5");
    sendCmd(16'h0040, 6'h03, 0, "R5");
    sendCmd(16'hFFFE, 6'h05, 0, "R5");
    // R7: DMA with and without enable
    sendCmd(16'h2000, 6'h21, 1, "R7");
    idle("R7");
    sendCmd(16'h2200, 6'h21, 0, "R7");
    sendCmd(16'h0300, 6'h01, 1, "R7");
    // R3: cancel by control read, then by data access
    stepCycle(1, 0, 0, 16'h7FFF, 0, "R3");
    stepCycle(0, 1, 0, 16'h0000, 0, "R3");
    stepCycle(1, 0, 0, 16'h1111, 0, "R3");
    stepCycle(0, 0, 1, 16'h0000, 0, "R3");
    idle("R3");
    // R4: cancel together with a first word, then with a second word
    stepCycle(1, 0, 1, 16'h4555, 1, "R4");
    stepCycle(1, 0, 0, 16'h8666, 1, "R4");
    stepCycle(1, 1, 0, 16'h00F3, 1, "R4");
    idle("R8");
    // R8: no pulse on cancel or first word alone
    stepCycle(0, 1, 1, 16'h0000, 0, "R8");
    idle("R8");

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule